// File: doc/BRIEF.md
# Supervisor Virtual Address Segment Checker

This block takes one memory access request (a 64-bit base value, a 16-bit signed displacement and the processor status fields) and classifies the effective address against the address map that applies at the supervisor privilege level. It works out whether the status fields place the processor at supervisor level and forms the effective address. It names the segment the address lands in, tells whether that segment is translated through the TLB, and raises an address error for holes in the map. The block does not perform the TLB lookup, does not decode the kernel or user maps, and does not vector exceptions.

Two address widths are supported, chosen by the width-select status bit. In the narrow (32-bit) width, the low 32 bits of the sum are sign-extended to 64 bits. A signed-overflow flag is also raised when the base and displacement share a sign that the 32-bit sum does not keep. In the wide (64-bit) width, the full 64-bit sum is decoded against three mapped windows.

Requests use a valid/ready stream with a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` after that edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `supv_seg_check`

## Requirements
- R1: The processor is at supervisor level only when `in_ksu` is 2'b01 and both `in_exl` and `in_erl` are 0. Otherwise `out_not_sup` is 1 and `out_seg` is 0, with `out_addr_err`, `out_mapped` and `out_ovf` all 0.
- R2: When `in_sx` is 1, `out_ea` equals `in_base` plus the displacement sign-extended to 64 bits, taken modulo 2^64. `out_ovf` is 0 in this width.
- R3: When `in_sx` is 0, `out_ea` is the 32-bit sum of `in_base[31:0]` and the sign-extended displacement, with its bit 31 copied into bits 63..32. Bits 63..32 of `in_base` have no effect.
- R4: At supervisor level with `in_sx` 0, `out_ovf` is 1 in exactly two cases. The first is when displacement bit 15, base bit 31 and sum bit 31 are 0, 0 and 1. The second is when they are 1, 1 and 0.
- R5: In narrow width, an effective address whose bit 31 is 0 gives segment code 3'd1 (low user-visible 2 GB region).
- R6: In narrow width, low-32 addresses 0xC000_0000..0xDFFF_FFFF give code 3'd2. The ranges 0x8000_0000..0xBFFF_FFFF and 0xE000_0000..0xFFFF_FFFF give code 3'd0 with `out_addr_err` 1.
- R7: In wide width, 0x0..0x0000_00FF_FFFF_FFFF gives code 3'd3 and 0x4000_0000_0000_0000..0x4000_00FF_FFFF_FFFF gives code 3'd4.
- R8: In wide width, 0xFFFF_FFFF_C000_0000..0xFFFF_FFFF_DFFF_FFFF gives code 3'd5. Every other wide address gives code 3'd0 with `out_addr_err` 1.
- R9: `out_mapped` is 1 exactly when the segment code is non-zero. At supervisor level, exactly one of `out_mapped` and `out_addr_err` is 1.
- R10: The overflow flag does not alter the segment code. The code is always decoded from `out_ea` as computed.
- R11: A request is taken when `in_valid && in_ready`, and its result shows with `out_valid` after that edge. `in_ready` is 1 when `out_valid` is 0 or `out_ready` is 1. While `out_valid && !out_ready`, all outputs stay unchanged.
- R12: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_base | input | 64 | Base register value |
| in_ofs | input | 16 | Signed displacement |
| in_ksu | input | 2 | Privilege level field (2'b01 = supervisor) |
| in_exl | input | 1 | Exception level bit |
| in_erl | input | 1 | Error level bit |
| in_sx | input | 1 | Address width select: 0 narrow, 1 wide |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ea | output | 64 | Effective address |
| out_seg | output | 3 | Segment code 0..5 |
| out_mapped | output | 1 | Segment is TLB-translated |
| out_addr_err | output | 1 | Address falls in an unmapped hole |
| out_ovf | output | 1 | Narrow-width signed overflow |
| out_not_sup | output | 1 | Status fields are not at supervisor level |

## Verification
The bench probes the edges of every window: the last and first byte around each hole, in both widths. A decoder that compares one bit too few or uses an inclusive bound in the wrong place misclassifies one of these addresses. Narrow-width requests carry garbage in the base's upper half and negative displacements. A design that adds 64 bits, or extends the sum from the wrong bit, gives a wrong address or a wide-map code. Both overflow cases are driven along with near misses. A wrong sign rule sets or misses the flag, and one that clears the segment on overflow gives code 0 for a mapped address. A stalled consumer checks that the held result does not change and that a second request waits.

// File: rtl/supv_seg_pkg.sv
package supv_seg_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned NARROW_W = 32;
  localparam int unsigned SEG_W    = 3;

  typedef enum logic [SEG_W-1:0] {
    SEG_NONE   = 3'd0,
    SEG_USR32  = 3'd1,
    SEG_SUP32  = 3'd2,
    SEG_USR64  = 3'd3,
    SEG_SUP64  = 3'd4,
    SEG_CMP64  = 3'd5
  } seg_code_e;

  localparam logic [1:0] PRIV_SUPERVISOR = 2'b01;
endpackage

// File: rtl/supv_mode_decode.sv
module supv_mode_decode (
  input  logic [1:0] ksu,
  input  logic       exl,
  input  logic       erl,
  output logic       is_sup
);
  import supv_seg_pkg::*;
  always_comb is_sup = (ksu == PRIV_SUPERVISOR) && !exl && !erl;
endmodule

// File: rtl/supv_ea_calc.sv
module supv_ea_calc #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned OFS_W    = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              wide,
  output logic [ADDR_W-1:0] ea,
  output logic              ovf_n
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;
  localparam int unsigned UP_W  = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0]   ofs_x;
  logic [ADDR_W-1:0]   sum_w;
  logic [NARROW_W-1:0] sum_n;
  logic                b_sign, o_sign, s_sign;

  always_comb begin
    ofs_x  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    sum_w  = base + ofs_x;
    sum_n  = base[NARROW_W-1:0] + ofs_x[NARROW_W-1:0];
    b_sign = base[NARROW_W-1];
    o_sign = ofs[OFS_W-1];
    s_sign = sum_n[NARROW_W-1];
    ovf_n  = (!o_sign && !b_sign && s_sign) || (o_sign && b_sign && !s_sign);
    ea     = wide ? sum_w : {{UP_W{s_sign}}, sum_n};
  end
endmodule

// File: rtl/supv_seg_map.sv
module supv_seg_map #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [ADDR_W-1:0]    ea,
  input  logic                 wide,
  input  logic                 is_sup,
  output supv_seg_pkg::seg_code_e seg,
  output logic                 addr_err
);
  import supv_seg_pkg::*;
  localparam int unsigned UP_W  = ADDR_W - NARROW_W;
  localparam int unsigned TB_LO = 40;               // 1 TB windows
  localparam int unsigned HI_W  = ADDR_W - TB_LO;
  localparam logic [HI_W-1:0] XSUP_TAG = {2'b01, {(HI_W-2){1'b0}}};

  logic       in_usr32, in_sup32, in_usr64, in_sup64, in_cmp64;
  logic [2:0] top3;

  always_comb begin
    top3     = ea[NARROW_W-1 -: 3];
    in_usr32 = !ea[NARROW_W-1];
    in_sup32 = (top3 == 3'b110);
    in_usr64 = (ea[ADDR_W-1:TB_LO] == '0);
    in_sup64 = (ea[ADDR_W-1:TB_LO] == XSUP_TAG);
    in_cmp64 = (ea[ADDR_W-1:NARROW_W] == {UP_W{1'b1}}) && (top3 == 3'b110);

    seg = SEG_NONE;
    if (is_sup) begin
      if (!wide) begin
        if (in_usr32)      seg = SEG_USR32;
        else if (in_sup32) seg = SEG_SUP32;
      end else begin
        if (in_usr64)      seg = SEG_USR64;
        else if (in_sup64) seg = SEG_SUP64;
        else if (in_cmp64) seg = SEG_CMP64;
      end
    end
    addr_err = is_sup && (seg == SEG_NONE);
  end
endmodule

// File: rtl/supv_seg_check.sv
module supv_seg_check #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned OFS_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [1:0]        in_ksu,
  input  logic              in_exl,
  input  logic              in_erl,
  input  logic              in_sx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_ea,
  output logic [2:0]        out_seg,
  output logic              out_mapped,
  output logic              out_addr_err,
  output logic              out_ovf,
  output logic              out_not_sup
);
  import supv_seg_pkg::*;

  logic              sup_c, ovf_c, err_c;
  logic [ADDR_W-1:0] ea_c;
  seg_code_e         seg_c;

  supv_mode_decode u_mode (
    .ksu(in_ksu), .exl(in_exl), .erl(in_erl), .is_sup(sup_c)
  );

  supv_ea_calc #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .OFS_W(OFS_W)) u_ea (
    .base(in_base), .ofs(in_ofs), .wide(in_sx), .ea(ea_c), .ovf_n(ovf_c)
  );

  supv_seg_map #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_map (
    .ea(ea_c), .wide(in_sx), .is_sup(sup_c), .seg(seg_c), .addr_err(err_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_ea       <= ea_c;
      out_seg      <= seg_c;
      out_mapped   <= (seg_c != SEG_NONE);
      out_addr_err <= err_c;
      out_ovf      <= sup_c && !in_sx && ovf_c;
      out_not_sup  <= !sup_c;
    end
  end
endmodule

// File: rtl/supv_seg_check_sva.sv
module supv_seg_check_sva #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_ea,
  input logic [2:0]        out_seg,
  input logic              out_mapped,
  input logic              out_addr_err,
  input logic              out_ovf,
  input logic              out_not_sup
);
  a_r1_not_sup_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_not_sup) |-> (out_seg == 3'd0 && !out_addr_err && !out_mapped && !out_ovf));

  a_r9_map_xor_err: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_not_sup) |-> (out_mapped != out_addr_err));

  a_r9_map_follows_seg: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mapped == (out_seg != 3'd0)));

  a_r8_seg_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_seg <= 3'd5));

  a_r11_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_seg)
                                   && $stable(out_ovf) && $stable(out_addr_err)));

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind supv_seg_check supv_seg_check_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/supv_seg_check_bench.sv
module supv_seg_check_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_exl, in_erl, in_sx;
  logic [63:0] in_base;
  logic [15:0] in_ofs;
  logic [1:0]  in_ksu;
  logic        out_valid, out_ready, out_mapped, out_addr_err, out_ovf, out_not_sup;
  logic [63:0] out_ea;
  logic [2:0]  out_seg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  supv_seg_check u_supv_seg_check (.*);

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent reference from the requirements
  task automatic expect_of(input [63:0] b, input [15:0] o, input [1:0] k,
                           input e, input r, input s,
                           output [63:0] ea, output [2:0] seg, output err,
                           output ovf, output nsup);
    logic [63:0] o64;
    logic [31:0] s32;
    o64 = {{48{o[15]}}, o};
    ovf = 0;
    if (s) ea = b + o64;
    else begin
      s32 = b[31:0] + o64[31:0];
      ea  = {{32{s32[31]}}, s32};
      ovf = (!o[15] && !b[31] && s32[31]) || (o[15] && b[31] && !s32[31]);
    end
    nsup = !(k == 2'b01 && !e && !r);
    seg = 0;
    if (!s) begin
      if (ea <= 64'h7FFF_FFFF) seg = 1;
      else if (ea >= 64'hFFFF_FFFF_C000_0000 && ea <= 64'hFFFF_FFFF_DFFF_FFFF) seg = 2;
    end else begin
      if (ea <= 64'h0000_00FF_FFFF_FFFF) seg = 3;
      else if (ea >= 64'h4000_0000_0000_0000 && ea <= 64'h4000_00FF_FFFF_FFFF) seg = 4;
      else if (ea >= 64'hFFFF_FFFF_C000_0000 && ea <= 64'hFFFF_FFFF_DFFF_FFFF) seg = 5;
    end
    err = (seg == 0);
    if (nsup) begin seg = 0; err = 0; ovf = 0; end
  endtask

  task automatic compare(input string req, input [63:0] b, input [15:0] o,
                         input [1:0] k, input e, input r, input s);
    logic [63:0] x_ea; logic [2:0] x_seg; logic x_err, x_ovf, x_ns;
    expect_of(b, o, k, e, r, s, x_ea, x_seg, x_err, x_ovf, x_ns);
    chk(req, out_valid === 1'b1, "out_valid", 64'(out_valid), 64'd1);
    chk(req, out_ea === x_ea, "ea", out_ea, x_ea);
    chk(req, out_seg === x_seg, "seg", 64'(out_seg), 64'(x_seg));
    chk(req, out_mapped === (x_seg != 0), "mapped", 64'(out_mapped), 64'(x_seg != 0));
    chk(req, out_addr_err === x_err, "addr_err", 64'(out_addr_err), 64'(x_err));
    chk(req, out_ovf === x_ovf, "ovf", 64'(out_ovf), 64'(x_ovf));
    chk(req, out_not_sup === x_ns, "not_sup", 64'(out_not_sup), 64'(x_ns));
  endtask

  task automatic drive(input [63:0] b, input [15:0] o, input [1:0] k,
                       input e, input r, input s);
    in_base = b; in_ofs = o; in_ksu = k; in_exl = e; in_erl = r; in_sx = s;
    in_valid = 1'b1;
  endtask

  task automatic run(input string req, input [63:0] b, input [15:0] o,
                     input [1:0] k, input e, input r, input s);
    @(negedge clk);
    drive(b, o, k, e, r, s);
    @(negedge clk);
    in_valid = 1'b0;
    compare(req, b, o, k, e, r, s);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(64'h0, 16'h0, 2'b01, 0, 0, 0); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", out_valid === 1'b0, "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R11", in_ready === 1'b1, "in_ready idle", 64'(in_ready), 64'd1);
    rst = 1'b0;
  endtask

  task automatic t_privilege();
    run("R1", 64'h1000, 16'h0010, 2'b00, 0, 0, 0);
    run("R1", 64'h1000, 16'h0010, 2'b10, 0, 0, 1);
    run("R1", 64'h8000_0000, 16'h0000, 2'b01, 1, 0, 0);
    run("R1", 64'h7FFF_FFF0, 16'h0020, 2'b01, 0, 1, 0);  // would overflow
    run("R1", 64'h1000, 16'h0010, 2'b11, 0, 0, 0);
  endtask

  task automatic t_narrow_map();
    run("R5", 64'h0000_0000_0000_1000, 16'h0010, 2'b01, 0, 0, 0);
    run("R3", 64'hDEAD_BEEF_0000_1000, 16'h0010, 2'b01, 0, 0, 0);
    run("R3", 64'h0000_0000_0000_0100, 16'hFF00, 2'b01, 0, 0, 0);
    run("R5", 64'h0000_0000_7FFF_FFFF, 16'h0000, 2'b01, 0, 0, 0);
    run("R6", 64'h0000_0000_8000_0000, 16'h0000, 2'b01, 0, 0, 0);
    run("R6", 64'h0000_0000_BFFF_FFFF, 16'h0000, 2'b01, 0, 0, 0);
    run("R6", 64'h0000_0000_C000_0000, 16'h0000, 2'b01, 0, 0, 0);
    run("R6", 64'h1234_5678_DFFF_FFFF, 16'h0000, 2'b01, 0, 0, 0);
    run("R6", 64'h0000_0000_E000_0000, 16'h0000, 2'b01, 0, 0, 0);
  endtask

  task automatic t_overflow();
    run("R4", 64'h0000_0000_7FFF_FFF0, 16'h0020, 2'b01, 0, 0, 0);
    run("R10", 64'h0000_0000_8000_0000, 16'hFFFF, 2'b01, 0, 0, 0);
    run("R4", 64'h0000_0000_8000_0010, 16'hFFF0, 2'b01, 0, 0, 0);
    run("R4", 64'h0000_0000_7FFF_FFF0, 16'hFFF0, 2'b01, 0, 0, 0);
    run("R10", 64'h0000_0000_5FFF_FFF0, 16'h7FFF, 2'b01, 0, 0, 0);
  endtask

  task automatic t_wide_map();
    run("R7", 64'h0, 16'h0, 2'b01, 0, 0, 1);
    run("R7", 64'h0000_00FF_FFFF_FFFF, 16'h0, 2'b01, 0, 0, 1);
    run("R2", 64'h0000_00FF_FFFF_FFF0, 16'h0020, 2'b01, 0, 0, 1);
    run("R7", 64'h4000_0000_0000_0000, 16'h0, 2'b01, 0, 0, 1);
    run("R7", 64'h4000_00FF_FFFF_FFFF, 16'h0, 2'b01, 0, 0, 1);
    run("R8", 64'h4000_0100_0000_0000, 16'h0, 2'b01, 0, 0, 1);
    run("R2", 64'h4000_0000_0000_0010, 16'hFFE0, 2'b01, 0, 0, 1);
    run("R8", 64'hFFFF_FFFF_C000_0000, 16'h0, 2'b01, 0, 0, 1);
    run("R8", 64'hFFFF_FFFF_DFFF_FFFF, 16'h0, 2'b01, 0, 0, 1);
    run("R8", 64'hFFFF_FFFF_BFFF_FFFF, 16'h0, 2'b01, 0, 0, 1);
    run("R8", 64'hFFFF_FFFF_E000_0000, 16'h0, 2'b01, 0, 0, 1);
    run("R8", 64'h0000_0000_C000_0000, 16'h0, 2'b01, 0, 0, 1);
    run("R2", 64'h0000_0000_7FFF_FFF0, 16'h0020, 2'b01, 0, 0, 1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h0000_0000_0000_2000, 16'h0004, 2'b01, 0, 0, 0);
    @(negedge clk);
    compare("R11", 64'h2000, 16'h0004, 2'b01, 0, 0, 0);
    chk("R11", in_ready === 1'b0, "in_ready stalled", 64'(in_ready), 64'd0);
    drive(64'hFFFF_FFFF_C000_0000, 16'h0000, 2'b01, 0, 0, 1);
    @(negedge clk);
    compare("R11", 64'h2000, 16'h0004, 2'b01, 0, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R11", 64'hFFFF_FFFF_C000_0000, 16'h0000, 2'b01, 0, 0, 1);
    @(negedge clk);
    chk("R11", out_valid === 1'b0, "out_valid drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h10, 16'h0, 2'b01, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R12", out_valid === 1'b0, "out_valid after mid reset", 64'(out_valid), 64'd0);
    rst = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    t_reset();
    t_privilege();
    t_narrow_map();
    t_overflow();
    t_wide_map();
    t_backpressure();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule